// File: doc/BRIEF.md
# Programmable-Latency Cache RAM Access Sequencer

This block sequences read accesses to two cache RAMs, a tag RAM and a data RAM, whose timing is set by static configuration fields. Each RAM has its own request port and its own sequencer. When a request is accepted, the sequencer can insert one setup cycle with the RAM idle. It then holds the RAM enable and the latched address for the programmed number of latency cycles and samples the read data on the last cycle of that window. Register-slice stages come next, and on the data path an optional inline-correction penalty of two cycles follows. After that the captured word is presented with a single-cycle valid pulse.

The tag and data paths decode their latency codes from different tables. The tag table saturates at five cycles, while the data table runs up to eight. Setup and slice stages are always added on top of the decoded latency and never replace any part of it. Each RAM has one access in flight at most. A requester issues its next request only once the valid pulse for the previous one has appeared. The configuration is sampled when a request is accepted.

Top module: `cram_access_seq`

## Requirements
- R1: The 3-bit tag latency code selects the tag access window: codes 0 and 1 give 2 cycles, 2 gives 3, 3 gives 4, and any code with bit 2 set gives 5.
- R2: The 3-bit data latency code selects the data access window: codes 0 and 1 give 2 cycles, and each code c from 2 to 7 gives c+1 cycles, so 7 gives 8.
- R3: When a path's setup bit is 1, one cycle with the RAM enable low passes between acceptance and the start of the access window. When the bit is 0, the window starts in the cycle right after acceptance. Each path uses only its own setup bit.
- R4: During the access window the RAM enable is high for exactly the decoded number of consecutive cycles, and the RAM address equals the address latched at acceptance. The enable is low at every other time.
- R5: The tag slice bit adds one cycle after the window when set. The 2-bit data slice code adds 0, 1 or 2 cycles for codes 0, 1 and 2. Code 3 is invalid: it adds 2 cycles and sets `slice_cfg_err` from the acceptance edge until the next accepted data request.
- R6: When both `ecc_en` and `inline_ecc_en` are 1, a data read takes 2 more cycles before its valid pulse. If either enable is 0, no cycles are added. The tag path never takes this penalty.
- R7: Read data is sampled on the last cycle of the access window. Counted from the accepting clock edge, the valid output rises after setup + window + slices + inline-penalty edges, stays high for one cycle, and the read data output holds the sampled word until the next capture.
- R8: A request that arrives while the path is busy is ignored: the address, timing and data of the access in flight are unchanged.
- R9: After reset, both RAM enables, both valid outputs and `slice_cfg_err` are 0.
- R10: The tag and data paths run independently, so requests accepted in the same cycle each finish with their own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tag_req | input | 1 | Tag read request |
| tag_addr | input | TAG_AW | Tag read address |
| tag_setup | input | 1 | Tag setup cycle enable |
| tag_lat | input | 3 | Tag latency code |
| tag_slice | input | 1 | Tag register slice present |
| tag_ram_en | output | 1 | Tag RAM enable |
| tag_ram_addr | output | TAG_AW | Tag RAM address |
| tag_ram_rdata | input | TAG_DW | Tag RAM read data |
| tag_rvalid | output | 1 | Tag read data valid pulse |
| tag_rdata | output | TAG_DW | Captured tag read data |
| data_req | input | 1 | Data read request |
| data_addr | input | DATA_AW | Data read address |
| data_setup | input | 1 | Data setup cycle enable |
| data_lat | input | 3 | Data latency code |
| data_slice | input | 2 | Data slice count code |
| ecc_en | input | 1 | Error correction enable |
| inline_ecc_en | input | 1 | Forward-corrected-only mode |
| data_ram_en | output | 1 | Data RAM enable |
| data_ram_addr | output | DATA_AW | Data RAM address |
| data_ram_rdata | input | DATA_DW | Data RAM read data |
| data_rvalid | output | 1 | Data read data valid pulse |
| data_rdata | output | DATA_DW | Captured data read data |
| slice_cfg_err | output | 1 | Invalid data slice code seen on the last accepted data request |

## Verification
The tag path is run through every combination of setup bit, latency code and slice bit. The data path is run through every combination of setup bit, latency code, slice code and the two error-correction enables. For each run the bench records the first enable cycle, the length of the enable run and the cycle of the valid pulse. Codes that share a latency are thereby told apart from neighbouring codes, setup is told apart from latency, and the slice stages and inline penalty, which only move the valid pulse, are told apart from the window. The RAM model returns a word derived from its address, so a capture taken one cycle early or late, or from the wrong address, shows up as wrong data. Separate runs send a second request with different fields in the middle of a long access, and launch both paths in the same cycle.

// File: rtl/cram_seq_pkg.sv
package cram_seq_pkg;

    localparam int CNT_W     = 4;
    localparam int EXTRA_W   = 3;
    localparam int INLINE_PEN = 2;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_SETUP,
        PS_ACCESS,
        PS_TAIL
    } path_state_e;

    typedef struct packed {
        logic               setup;
        logic [CNT_W-1:0]   lat;
        logic [EXTRA_W-1:0] extra;
    } timing_t;

    // tag table saturates at 5 cycles
    function automatic logic [CNT_W-1:0] tag_lat_cycles(input logic [2:0] code);
        logic [CNT_W-1:0] r;
        if (code[2])
            r = CNT_W'(5);
        else if (code[1:0] <= 2'd1)
            r = CNT_W'(2);
        else
            r = CNT_W'(code) + CNT_W'(1);
        return r;
    endfunction

    // data table runs linearly up to 8 cycles
    function automatic logic [CNT_W-1:0] data_lat_cycles(input logic [2:0] code);
        logic [CNT_W-1:0] r;
        if (code <= 3'd1)
            r = CNT_W'(2);
        else
            r = CNT_W'(code) + CNT_W'(1);
        return r;
    endfunction

    // invalid code 3 is clamped to 2 stages
    function automatic logic [EXTRA_W-1:0] data_slice_stages(input logic [1:0] code);
        logic [EXTRA_W-1:0] r;
        if (code == 2'b11)
            r = EXTRA_W'(2);
        else
            r = EXTRA_W'(code);
        return r;
    endfunction

endpackage

// File: rtl/cram_tag_timing.sv
module cram_tag_timing
    import cram_seq_pkg::*;
(
    input  logic       setup_bit,
    input  logic [2:0] lat_code,
    input  logic       slice_bit,
    output timing_t    tcfg
);

    always_comb begin
        tcfg.setup = setup_bit;
        tcfg.lat   = tag_lat_cycles(lat_code);
        tcfg.extra = EXTRA_W'(slice_bit);
    end

endmodule

// File: rtl/cram_data_timing.sv
module cram_data_timing
    import cram_seq_pkg::*;
(
    input  logic       setup_bit,
    input  logic [2:0] lat_code,
    input  logic [1:0] slice_code,
    input  logic       ecc_on,
    input  logic       inline_on,
    output timing_t    tcfg,
    output logic       bad_slice
);

    logic [EXTRA_W-1:0] pen;

    always_comb begin
        pen        = (ecc_on && inline_on) ? EXTRA_W'(INLINE_PEN) : '0;
        tcfg.setup = setup_bit;
        tcfg.lat   = data_lat_cycles(lat_code);
        tcfg.extra = data_slice_stages(slice_code) + pen;
        bad_slice  = (slice_code == 2'b11);
    end

endmodule

// File: rtl/cram_path_seq.sv
module cram_path_seq
    import cram_seq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW-1:0] addr,
    input  timing_t       tcfg,
    output logic          accepted,
    output logic          ram_en,
    output logic [AW-1:0] ram_addr,
    input  logic [DW-1:0] ram_rdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);

    path_state_e          state_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     lat_q;
    logic [EXTRA_W-1:0]   extra_q;
    logic [AW-1:0]        addr_q;
    logic [DW-1:0]        rdata_q;
    logic                 rvalid_q;

    assign accepted = (state_q == PS_IDLE) && req;
    assign ram_en   = (state_q == PS_ACCESS);
    assign ram_addr = addr_q;
    assign rvalid   = rvalid_q;
    assign rdata    = rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PS_IDLE;
            cnt_q    <= '0;
            lat_q    <= '0;
            extra_q  <= '0;
            addr_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            unique case (state_q)
                PS_IDLE: begin
                    if (req) begin
                        addr_q  <= addr;
                        lat_q   <= tcfg.lat;
                        extra_q <= tcfg.extra;
                        if (tcfg.setup) begin
                            state_q <= PS_SETUP;
                        end else begin
                            state_q <= PS_ACCESS;
                            cnt_q   <= tcfg.lat - CNT_W'(1);
                        end
                    end
                end
                PS_SETUP: begin
                    state_q <= PS_ACCESS;
                    cnt_q   <= lat_q - CNT_W'(1);
                end
                PS_ACCESS: begin
                    if (cnt_q == '0) begin
                        rdata_q <= ram_rdata;
                        if (extra_q == '0) begin
                            rvalid_q <= 1'b1;
                            state_q  <= PS_IDLE;
                        end else begin
                            state_q <= PS_TAIL;
                            cnt_q   <= CNT_W'(extra_q) - CNT_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PS_TAIL: begin
                    if (cnt_q == '0) begin
                        rvalid_q <= 1'b1;
                        state_q  <= PS_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    // R4: address does not move while the enable stays high
    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        ram_en |=> (!ram_en || $stable(ram_addr)));

    // R4: window counter never exceeds the latched latency
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_ACCESS) |-> (cnt_q < lat_q));

    // R7: valid is a single-cycle pulse
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    // R7: valid only follows an access window or slice tail
    a_r7_valid_source: assert property (@(posedge clk) disable iff (rst)
        $rose(rvalid) |-> ($past(state_q) == PS_ACCESS || $past(state_q) == PS_TAIL));

    // R8: latched address is untouched while busy
    a_r8_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_IDLE) |=> $stable(addr_q));

endmodule

// File: rtl/cram_access_seq.sv
module cram_access_seq
    import cram_seq_pkg::*;
#(
    parameter int TAG_AW  = 8,
    parameter int TAG_DW  = 16,
    parameter int DATA_AW = 10,
    parameter int DATA_DW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tag_req,
    input  logic [TAG_AW-1:0]  tag_addr,
    input  logic               tag_setup,
    input  logic [2:0]         tag_lat,
    input  logic               tag_slice,
    output logic               tag_ram_en,
    output logic [TAG_AW-1:0]  tag_ram_addr,
    input  logic [TAG_DW-1:0]  tag_ram_rdata,
    output logic               tag_rvalid,
    output logic [TAG_DW-1:0]  tag_rdata,
    input  logic               data_req,
    input  logic [DATA_AW-1:0] data_addr,
    input  logic               data_setup,
    input  logic [2:0]         data_lat,
    input  logic [1:0]         data_slice,
    input  logic               ecc_en,
    input  logic               inline_ecc_en,
    output logic               data_ram_en,
    output logic [DATA_AW-1:0] data_ram_addr,
    input  logic [DATA_DW-1:0] data_ram_rdata,
    output logic               data_rvalid,
    output logic [DATA_DW-1:0] data_rdata,
    output logic               slice_cfg_err
);

    timing_t tag_t;
    timing_t data_t;
    logic    data_bad;
    logic    tag_acc;
    logic    data_acc;
    logic    err_q;

    cram_tag_timing u_tag_timing (
        .setup_bit (tag_setup),
        .lat_code  (tag_lat),
        .slice_bit (tag_slice),
        .tcfg      (tag_t)
    );

    cram_data_timing u_data_timing (
        .setup_bit  (data_setup),
        .lat_code   (data_lat),
        .slice_code (data_slice),
        .ecc_on     (ecc_en),
        .inline_on  (inline_ecc_en),
        .tcfg       (data_t),
        .bad_slice  (data_bad)
    );

    cram_path_seq #(.AW(TAG_AW), .DW(TAG_DW)) u_tag_path (
        .clk       (clk),
        .rst       (rst),
        .req       (tag_req),
        .addr      (tag_addr),
        .tcfg      (tag_t),
        .accepted  (tag_acc),
        .ram_en    (tag_ram_en),
        .ram_addr  (tag_ram_addr),
        .ram_rdata (tag_ram_rdata),
        .rvalid    (tag_rvalid),
        .rdata     (tag_rdata)
    );

    cram_path_seq #(.AW(DATA_AW), .DW(DATA_DW)) u_data_path (
        .clk       (clk),
        .rst       (rst),
        .req       (data_req),
        .addr      (data_addr),
        .tcfg      (data_t),
        .accepted  (data_acc),
        .ram_en    (data_ram_en),
        .ram_addr  (data_ram_addr),
        .ram_rdata (data_ram_rdata),
        .rvalid    (data_rvalid),
        .rdata     (data_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (data_acc)
            err_q <= data_bad;
    end

    assign slice_cfg_err = err_q;

    // R1: decoded tag window stays inside 2..5
    a_r1_tag_lat_range: assert property (@(posedge clk) disable iff (rst)
        tag_acc |-> (tag_t.lat >= CNT_W'(2) && tag_t.lat <= CNT_W'(5)));

    // R2: decoded data window stays inside 2..8
    a_r2_data_lat_range: assert property (@(posedge clk) disable iff (rst)
        data_acc |-> (data_t.lat >= CNT_W'(2) && data_t.lat <= CNT_W'(8)));

    // R5: error flag rises only after an invalid slice code is accepted
    a_r5_err_code: assert property (@(posedge clk) disable iff (rst)
        $rose(slice_cfg_err) |-> ($past(data_slice) == 2'b11));

    // R6: tail on the data path is bounded by two slices plus the inline penalty
    a_r6_extra_bound: assert property (@(posedge clk) disable iff (rst)
        data_acc |-> (data_t.extra <= EXTRA_W'(2 + INLINE_PEN)));

endmodule

// File: tb/cram_access_seq_tb.sv
module cram_access_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TAW = 8;
    localparam int TDW = 16;
    localparam int DAW = 10;
    localparam int DDW = 32;
    localparam int WATCHDOG = 150000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tag_req = 1'b0;
    logic [TAW-1:0] tag_addr = '0;
    logic           tag_setup = 1'b0;
    logic [2:0]     tag_lat = '0;
    logic           tag_slice = 1'b0;
    logic           tag_ram_en;
    logic [TAW-1:0] tag_ram_addr;
    logic [TDW-1:0] tag_ram_rdata;
    logic           tag_rvalid;
    logic [TDW-1:0] tag_rdata;
    logic           data_req = 1'b0;
    logic [DAW-1:0] data_addr = '0;
    logic           data_setup = 1'b0;
    logic [2:0]     data_lat = '0;
    logic [1:0]     data_slice = '0;
    logic           ecc_en = 1'b0;
    logic           inline_ecc_en = 1'b0;
    logic           data_ram_en;
    logic [DAW-1:0] data_ram_addr;
    logic [DDW-1:0] data_ram_rdata;
    logic           data_rvalid;
    logic [DDW-1:0] data_rdata;
    logic           slice_cfg_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [TDW-1:0] tag_word(input logic [TAW-1:0] a);
        return {a ^ 8'h5A, a};
    endfunction

    function automatic logic [DDW-1:0] data_word(input logic [DAW-1:0] a);
        return {12'hC3A, a ^ 10'h155, a};
    endfunction

    // RAM models: output only while enabled
    assign tag_ram_rdata  = tag_ram_en  ? tag_word(tag_ram_addr)   : '0;
    assign data_ram_rdata = data_ram_en ? data_word(data_ram_addr) : '0;

    cram_access_seq #(.TAG_AW(TAW), .TAG_DW(TDW), .DATA_AW(DAW), .DATA_DW(DDW)) dut_i (
        .clk(clk), .rst(rst),
        .tag_req(tag_req), .tag_addr(tag_addr), .tag_setup(tag_setup),
        .tag_lat(tag_lat), .tag_slice(tag_slice),
        .tag_ram_en(tag_ram_en), .tag_ram_addr(tag_ram_addr), .tag_ram_rdata(tag_ram_rdata),
        .tag_rvalid(tag_rvalid), .tag_rdata(tag_rdata),
        .data_req(data_req), .data_addr(data_addr), .data_setup(data_setup),
        .data_lat(data_lat), .data_slice(data_slice),
        .ecc_en(ecc_en), .inline_ecc_en(inline_ecc_en),
        .data_ram_en(data_ram_en), .data_ram_addr(data_ram_addr), .data_ram_rdata(data_ram_rdata),
        .data_rvalid(data_rvalid), .data_rdata(data_rdata),
        .slice_cfg_err(slice_cfg_err)
    );

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_tag_lat(input int c);
        if (c >= 4) return 5;
        if (c <= 1) return 2;
        return c + 1;
    endfunction

    function automatic int exp_data_lat(input int c);
        if (c <= 1) return 2;
        return c + 1;
    endfunction

    // one tag access; returns after valid pulse has been checked
    task automatic run_tag(input int s, input int l, input int sl, input logic [TAW-1:0] a);
        int first_en = -1;
        int en_cnt = 0;
        int vk = -1;
        bit addr_ok = 1'b1;
        int lat = exp_tag_lat(l);
        tag_setup = s[0]; tag_lat = l[2:0]; tag_slice = sl[0];
        tag_addr = a; tag_req = 1'b1;
        step();
        tag_req = 1'b0; tag_addr = ~a;
        for (int k = 0; k < 40; k++) begin
            if (tag_ram_en) begin
                if (first_en < 0) first_en = k;
                en_cnt++;
                if (tag_ram_addr != a) addr_ok = 1'b0;
            end
            if (tag_rvalid) begin vk = k; break; end
            step();
        end
        check(first_en == s, "R3 tag setup / first enable cycle", first_en, s);
        check(en_cnt == lat, "R1 tag window length", en_cnt, lat);
        check(addr_ok, "R4 tag address during window", addr_ok, 1);
        check(vk == s + lat + sl, "R5 R7 tag valid cycle", vk, s + lat + sl);
        check(tag_rdata == tag_word(a), "R7 tag read data", tag_rdata, tag_word(a));
        step();
        check(!tag_rvalid, "R7 tag valid pulse width", tag_rvalid, 0);
        check(tag_rdata == tag_word(a), "R7 tag data held", tag_rdata, tag_word(a));
        check(!tag_ram_en, "R4 tag enable low after access", tag_ram_en, 0);
    endtask

    task automatic run_data(input int s, input int l, input int sl, input int e,
                            input int inl, input logic [DAW-1:0] a, input bit poke);
        int first_en = -1;
        int en_cnt = 0;
        int vk = -1;
        bit addr_ok = 1'b1;
        int lat = exp_data_lat(l);
        int ex = ((sl == 3) ? 2 : sl) + ((e != 0 && inl != 0) ? 2 : 0);
        data_setup = s[0]; data_lat = l[2:0]; data_slice = sl[1:0];
        ecc_en = e[0]; inline_ecc_en = inl[0];
        data_addr = a; data_req = 1'b1;
        step();
        data_req = 1'b0; data_addr = ~a;
        check(slice_cfg_err == (sl == 3), "R5 slice error flag", slice_cfg_err, sl == 3);
        for (int k = 0; k < 40; k++) begin
            if (poke && k == 3) begin
                // R8: second request mid-access with different fields
                data_req = 1'b1; data_addr = a ^ 10'h2AA;
                data_setup = 1'b0; data_lat = 3'd0; data_slice = 2'd0; ecc_en = 1'b0;
            end else begin
                data_req = 1'b0;
            end
            if (data_ram_en) begin
                if (first_en < 0) first_en = k;
                en_cnt++;
                if (data_ram_addr != a) addr_ok = 1'b0;
            end
            if (data_rvalid) begin vk = k; break; end
            step();
        end
        data_req = 1'b0;
        check(first_en == s, "R3 data setup / first enable cycle", first_en, s);
        check(en_cnt == lat, "R2 data window length", en_cnt, lat);
        check(addr_ok, "R4 data address during window", addr_ok, 1);
        check(vk == s + lat + ex, "R5 R6 R7 data valid cycle", vk, s + lat + ex);
        check(data_rdata == data_word(a), "R7 data read data", data_rdata, data_word(a));
        step();
        check(!data_rvalid, "R7 data valid pulse width", data_rvalid, 0);
        check(!data_ram_en, "R8 no access started by ignored request", data_ram_en, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        // R9 reset state
        check(!tag_ram_en && !data_ram_en, "R9 enables after reset", {tag_ram_en, data_ram_en}, 0);
        check(!tag_rvalid && !data_rvalid, "R9 valids after reset", {tag_rvalid, data_rvalid}, 0);
        check(!slice_cfg_err, "R9 error flag after reset", slice_cfg_err, 0);

        // R1 R3 R5: full tag sweep
        for (int s = 0; s < 2; s++)
            for (int l = 0; l < 8; l++)
                for (int sl = 0; sl < 2; sl++)
                    run_tag(s, l, sl, TAW'(s * 97 + l * 13 + sl * 5 + 1));

        // R2 R3 R5 R6: full data sweep
        for (int s = 0; s < 2; s++)
            for (int l = 0; l < 8; l++)
                for (int sl = 0; sl < 4; sl++)
                    for (int e = 0; e < 2; e++)
                        for (int i = 0; i < 2; i++)
                            run_data(s, l, sl, e, i, DAW'(s * 301 + l * 37 + sl * 11 + e * 3 + i + 2), 1'b0);

        // R8: request during a long access is ignored
        run_data(1, 7, 2, 1, 1, 10'h1F3, 1'b1);
        // R5: valid slice code clears the flag again
        run_data(0, 2, 1, 0, 0, 10'h045, 1'b0);

        // R10: both paths launched in the same cycle
        begin
            int tk = -1;
            int dk = -1;
            tag_setup = 1'b0; tag_lat = 3'd0; tag_slice = 1'b0; tag_addr = 8'h3C; tag_req = 1'b1;
            data_setup = 1'b1; data_lat = 3'd7; data_slice = 2'd2; ecc_en = 1'b1; inline_ecc_en = 1'b1;
            data_addr = 10'h2D1; data_req = 1'b1;
            step();
            tag_req = 1'b0; data_req = 1'b0;
            for (int k = 0; k < 40; k++) begin
                if (tag_rvalid && tk < 0) tk = k;
                if (data_rvalid && dk < 0) dk = k;
                if (dk >= 0) break;
                step();
            end
            check(tk == 2, "R10 tag timing with data busy", tk, 2);
            check(dk == 13, "R10 data timing with tag busy", dk, 13);
            check(tag_rdata == tag_word(8'h3C), "R10 tag data", tag_rdata, tag_word(8'h3C));
            check(data_rdata == data_word(10'h2D1), "R10 data data", data_rdata, data_word(10'h2D1));
        end

        step();
        finish_run();
    end

endmodule